// File: doc/BRIEF.md
# Debug Trigger Register Bank

This block holds the machine-mode debug trigger registers of a small RISC-V core. It has a trigger select register, a fixed capability register, and, for each implemented trigger, a control word and a compare value. A slot for a third data word is also decoded, but it holds no state. Software reaches all of these through one CSR port: an address, write data, a write strobe, and read data. Read data is combinational. A write takes effect at the clock edge on which the strobe is high.

A control-word write is legalized before it is stored:

- The trigger kind comes from the top four bits of the written value. Only the two address/data-match kinds (2 and 6) are accepted; any other kind leaves the stored word unchanged.
- The privilege enables and the load/store/execute enables are kept as written.
- The size code is kept only if it names a supported access width; otherwise the size field is stored as zero ("any size").
- Every other field is stored as zero. This covers dmode, match, chain, action, timing, select and hit.

The stored control words and compare values of all triggers are exported in parallel to the address-match logic.

Top module: `dbgtrig_bank`

## Requirements
- R1: After reset the select register reads 0. Every trigger's control word reads kind 2 in bits XLEN-1:XLEN-4 with all other bits zero (0x20000000 at XLEN=32). Every compare value reads 0.
- R2: A write to the select register (address 0x7A0) is stored only when the written value is below NUM_TRIG. Otherwise the previous value is kept.
- R3: The capability register (address 0x7A4) always reads 0x44, with bits 2 and 6 set, and ignores writes.
- R4: A control-word write (address 0x7A1) of kind 2 stores the kind, the execute/store/load bits 2:0, U at bit 3, S at bit 4, M at bit 6 and the size bits 17:16. On a 64-bit core it also stores size-high bits 22:21. All other bits, including dmode (bit XLEN-5), read back as zero.
- R5: A control-word write of kind 6 stores the kind, bits 4:0, bit 6, VU at bit 23 and VS at bit 24. The 4-bit size at bits 19:16 is stored only when the code is 0, 1, 2, 3 or 5; any other code is stored as 0. All other bits read as zero.
- R6: A control-word write whose kind field is neither 2 nor 6 leaves the selected trigger's control word unchanged.
- R7: A compare-value write (address 0x7A2) is stored only into the selected trigger and reads back unchanged.
- R8: The third data word (address 0x7A3) reads as zero, and writes to it change no state.
- R9: Output trig_ctrl_o slice i and trig_cmp_o slice i carry trigger i's stored control word and compare value. They follow a write from the next clock edge.
- R10: Reads of addresses outside 0x7A0 to 0x7A4 return zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | XLEN | CSR write data |
| csr_we | input | 1 | Write strobe, one write per cycle |
| csr_rdata | output | XLEN | Combinational read data for csr_addr |
| trig_ctrl_o | output | NUM_TRIG*XLEN | Stored control words, trigger i at slice i |
| trig_cmp_o | output | NUM_TRIG*XLEN | Stored compare values, trigger i at slice i |

## Verification
A select register that holds the wrong index shows on the very next read of address 0x7A0. It also sends the following control or compare write into the wrong slice of the exported buses, which is visible one edge after that write. A legalization fault, such as a field left uncleared or an illegal size kept, is visible at the control-word readback and on trig_ctrl_o from the clock edge that stores the write. For that reason each scenario reads back every affected register and both exported slices right after its writes.

// File: rtl/dbgtrig_pkg.sv
// Package: shared constants and helper functions for the debug trigger bank.
// Assumes XLEN is 32 or 64 and that masks are truncated to XLEN by the user.
package dbgtrig_pkg;

    typedef enum logic [3:0] {
        TK_NONE     = 4'd0,
        TK_MATCH    = 4'd2,
        TK_ICOUNT   = 4'd3,
        TK_IRQ      = 4'd4,
        TK_EXC      = 4'd5,
        TK_MATCH6   = 4'd6,
        TK_EXTSRC   = 4'd7,
        TK_UNAVAIL  = 4'd15
    } trig_kind_e;

    // CSR addresses
    localparam logic [11:0] A_SEL  = 12'h7A0;
    localparam logic [11:0] A_CTRL = 12'h7A1;
    localparam logic [11:0] A_CMP  = 12'h7A2;
    localparam logic [11:0] A_AUX  = 12'h7A3;
    localparam logic [11:0] A_CAP  = 12'h7A4;

    // Capability value: bits for the two match kinds
    localparam logic [63:0] CAP_VALUE = 64'h44;

    // Field masks (XLEN-independent low fields)
    localparam logic [63:0] KEEP_K2    = 64'h0000_005F;
    localparam logic [63:0] SIZE_K2_LO = 64'h0003_0000;
    localparam logic [63:0] SIZE_K2_HI = 64'h0060_0000;
    localparam logic [63:0] KEEP_K6    = 64'h0180_005F;
    localparam logic [63:0] SIZE_K6    = 64'h000F_0000;

    // Size codes with a supported access width: any, 1, 2, 4, 8 bytes
    function automatic logic size_ok(input logic [3:0] code);
        return (code <= 4'd3) || (code == 4'd5);
    endfunction

    // Which data word (1..3) a trigger kind makes accessible
    function automatic logic reg_present(input logic [3:0] kind, input logic [1:0] idx);
        case (kind)
            TK_MATCH, TK_MATCH6, TK_IRQ, TK_EXC, TK_UNAVAIL: return idx != 2'd0;
            TK_ICOUNT: return (idx == 2'd1) || (idx == 2'd3);
            TK_EXTSRC: return idx == 2'd1;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/dbgtrig_legalize.sv
// Module: turns a raw control-word write value into the value to store.
// Assumes XLEN is 32 or 64. Purely combinational; accept_o is low for any
// kind other than the two address-match kinds.
module dbgtrig_legalize
    import dbgtrig_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] wdata,
    output logic            accept_o,
    output logic [XLEN-1:0] legal_o
);
    localparam int KIND_LSB = XLEN - 4;
    localparam logic [XLEN-1:0] M_KEEP2 = XLEN'(KEEP_K2);
    localparam logic [XLEN-1:0] M_SZ2   = (XLEN > 32) ? XLEN'(SIZE_K2_LO | SIZE_K2_HI)
                                                      : XLEN'(SIZE_K2_LO);
    localparam logic [XLEN-1:0] M_KEEP6 = XLEN'(KEEP_K6);
    localparam logic [XLEN-1:0] M_SZ6   = XLEN'(SIZE_K6);

    logic [3:0]      kind;
    logic [3:0]      size2;
    logic [3:0]      size6;
    logic [XLEN-1:0] kind_bits;

    // Extract kind and size codes from the written value
    always_comb begin
        kind      = wdata[XLEN-1 -: 4];
        size2     = (XLEN > 32) ? {wdata[22:21], wdata[17:16]} : {2'b00, wdata[17:16]};
        size6     = wdata[19:16];
        kind_bits = {kind, {KIND_LSB{1'b0}}};
    end

    // Build the stored word field by field
    always_comb begin
        accept_o = 1'b0;
        legal_o  = '0;
        if (kind == TK_MATCH) begin
            accept_o = 1'b1;
            legal_o  = kind_bits | (wdata & M_KEEP2) |
                       (size_ok(size2) ? (wdata & M_SZ2) : '0);
        end else if (kind == TK_MATCH6) begin
            accept_o = 1'b1;
            legal_o  = kind_bits | (wdata & M_KEEP6) |
                       (size_ok(size6) ? (wdata & M_SZ6) : '0);
        end
    end
endmodule

// File: rtl/dbgtrig_slot.sv
// Module: storage for one trigger, a control word and a compare value.
// Assumes the writer only presents legalized control words. Resets to
// kind 2 with all fields zero.
module dbgtrig_slot
    import dbgtrig_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_ctrl,
    input  logic [XLEN-1:0] ctrl_new,
    input  logic            wr_cmp,
    input  logic [XLEN-1:0] cmp_new,
    output logic [XLEN-1:0] ctrl_q,
    output logic [XLEN-1:0] cmp_q
);
    localparam int KIND_LSB = XLEN - 4;
    localparam logic [XLEN-1:0] RESET_CTRL = {TK_MATCH, {KIND_LSB{1'b0}}};
    localparam logic [XLEN-1:0] M_KIND  = {4'hF, {KIND_LSB{1'b0}}};
    localparam logic [XLEN-1:0] OK_K2   = M_KIND | XLEN'(KEEP_K2) |
        ((XLEN > 32) ? XLEN'(SIZE_K2_LO | SIZE_K2_HI) : XLEN'(SIZE_K2_LO));
    localparam logic [XLEN-1:0] OK_K6   = M_KIND | XLEN'(KEEP_K6) | XLEN'(SIZE_K6);

    // Control word register
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= RESET_CTRL;
        else if (wr_ctrl) ctrl_q <= ctrl_new;
    end

    // Compare value register
    always_ff @(posedge clk) begin
        if (!rst_n)      cmp_q <= '0;
        else if (wr_cmp) cmp_q <= cmp_new;
    end

    // R6: only match kinds are ever stored
    a_r6_kind_match: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[XLEN-1 -: 4] == TK_MATCH) || (ctrl_q[XLEN-1 -: 4] == TK_MATCH6));

    // R4: kind 2 word has no bits outside its kept fields
    a_r4_k2_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[XLEN-1 -: 4] == TK_MATCH) |-> ((ctrl_q & ~OK_K2) == '0));

    // R5: kind 6 word has no stray bits and a supported size code
    a_r5_k6_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[XLEN-1 -: 4] == TK_MATCH6) |->
            (((ctrl_q & ~OK_K6) == '0) && size_ok(ctrl_q[19:16])));
endmodule

// File: rtl/dbgtrig_bank.sv
// Module: top of the debug trigger register bank. Decodes the CSR port,
// holds the select register, instantiates one slot per trigger and exports
// stored values. Assumes at most one write per cycle; reads are combinational.
module dbgtrig_bank
    import dbgtrig_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int NUM_TRIG = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [11:0]              csr_addr,
    input  logic [XLEN-1:0]          csr_wdata,
    input  logic                     csr_we,
    output logic [XLEN-1:0]          csr_rdata,
    output logic [NUM_TRIG*XLEN-1:0] trig_ctrl_o,
    output logic [NUM_TRIG*XLEN-1:0] trig_cmp_o
);
    localparam int SEL_W = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1;

    logic [SEL_W-1:0] sel_q;
    logic [XLEN-1:0]  ctrl_arr [NUM_TRIG];
    logic [XLEN-1:0]  cmp_arr  [NUM_TRIG];
    logic [XLEN-1:0]  ctrl_sel;
    logic [XLEN-1:0]  cmp_sel;
    logic [3:0]       kind_sel;
    logic             leg_accept;
    logic [XLEN-1:0]  leg_value;
    logic             wr_sel_ok;
    logic             wr_ctrl_any;
    logic             wr_cmp_any;

    // Selected trigger view and write qualification
    always_comb begin
        ctrl_sel    = ctrl_arr[sel_q];
        cmp_sel     = cmp_arr[sel_q];
        kind_sel    = ctrl_sel[XLEN-1 -: 4];
        wr_sel_ok   = csr_we && (csr_addr == A_SEL) && (csr_wdata < XLEN'(NUM_TRIG));
        wr_ctrl_any = csr_we && (csr_addr == A_CTRL) && leg_accept;
        wr_cmp_any  = csr_we && (csr_addr == A_CMP) && reg_present(kind_sel, 2'd2);
    end

    // Select register, updated only for in-range values
    always_ff @(posedge clk) begin
        if (!rst_n)         sel_q <= '0;
        else if (wr_sel_ok) sel_q <= csr_wdata[SEL_W-1:0];
    end

    dbgtrig_legalize #(.XLEN(XLEN)) legal_i (
        .wdata    (csr_wdata),
        .accept_o (leg_accept),
        .legal_o  (leg_value)
    );

    for (genvar i = 0; i < NUM_TRIG; i++) begin : g_slot
        dbgtrig_slot #(.XLEN(XLEN)) slot_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_ctrl  (wr_ctrl_any && (sel_q == SEL_W'(i))),
            .ctrl_new (leg_value),
            .wr_cmp   (wr_cmp_any && (sel_q == SEL_W'(i))),
            .cmp_new  (csr_wdata),
            .ctrl_q   (ctrl_arr[i]),
            .cmp_q    (cmp_arr[i])
        );
        assign trig_ctrl_o[i*XLEN +: XLEN] = ctrl_arr[i];
        assign trig_cmp_o[i*XLEN +: XLEN]  = cmp_arr[i];
    end

    // Read multiplexer
    always_comb begin
        case (csr_addr)
            A_SEL:   csr_rdata = {{(XLEN-SEL_W){1'b0}}, sel_q};
            A_CTRL:  csr_rdata = reg_present(kind_sel, 2'd1) ? ctrl_sel : '0;
            A_CMP:   csr_rdata = reg_present(kind_sel, 2'd2) ? cmp_sel : '0;
            A_CAP:   csr_rdata = XLEN'(CAP_VALUE);
            default: csr_rdata = '0;
        endcase
    end

    // R2: select never leaves the implemented range
    a_r2_sel_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(sel_q) < NUM_TRIG);

    // R2: out-of-range select write keeps the old value
    a_r2_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && (csr_addr == A_SEL) && (csr_wdata >= XLEN'(NUM_TRIG))) |=> $stable(sel_q));

    // R6: a write of an unsupported kind leaves all control words alone
    a_r6_kind_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && (csr_addr == A_CTRL) && (csr_wdata[XLEN-1 -: 4] != TK_MATCH) &&
         (csr_wdata[XLEN-1 -: 4] != TK_MATCH6)) |=> $stable(trig_ctrl_o));

    // R8: third data word writes change no exported state
    a_r8_aux_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && (csr_addr == A_AUX)) |=> ($stable(trig_ctrl_o) && $stable(trig_cmp_o)));
endmodule

// File: tb/dbgtrig_bank_tb.sv
`timescale 1ns/1ps
// Directed bench for the debug trigger bank, one task per scenario.
module dbgtrig_bank_tb_top;
    localparam int XLEN = 32;
    localparam int NT   = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [11:0]     csr_addr = 12'h000;
    logic [XLEN-1:0] csr_wdata = '0;
    logic            csr_we = 1'b0;
    logic [XLEN-1:0] csr_rdata;
    logic [NT*XLEN-1:0] trig_ctrl_o;
    logic [NT*XLEN-1:0] trig_cmp_o;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    dbgtrig_bank #(.XLEN(XLEN), .NUM_TRIG(NT)) dut_i (
        .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
        .csr_we(csr_we), .csr_rdata(csr_rdata),
        .trig_ctrl_o(trig_ctrl_o), .trig_cmp_o(trig_cmp_o)
    );

    task automatic check(input string tag, input logic [XLEN-1:0] got, input logic [XLEN-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [XLEN-1:0] d);
        @(negedge clk);
        csr_addr = a; csr_wdata = d; csr_we = 1'b1;
        @(negedge clk);
        csr_we = 1'b0; csr_wdata = '0;
    endtask

    task automatic rd_check(input string tag, input logic [11:0] a, input logic [XLEN-1:0] exp);
        @(negedge clk);
        csr_addr = a; csr_we = 1'b0;
        #1;
        check(tag, csr_rdata, exp);
    endtask

    task automatic t_reset;
        rd_check("R1 select", 12'h7A0, 32'h0);
        rd_check("R1 ctrl0", 12'h7A1, 32'h2000_0000);
        rd_check("R1 cmp0", 12'h7A2, 32'h0);
        check("R1 ctrl_o0", trig_ctrl_o[31:0], 32'h2000_0000);
        check("R1 ctrl_o1", trig_ctrl_o[63:32], 32'h2000_0000);
        check("R1 cmp_o", trig_cmp_o[31:0] | trig_cmp_o[63:32], 32'h0);
    endtask

    task automatic t_select;
        wr(12'h7A0, 32'd1);
        rd_check("R2 select in range", 12'h7A0, 32'd1);
        wr(12'h7A0, 32'd2);
        rd_check("R2 select eq count", 12'h7A0, 32'd1);
        wr(12'h7A0, 32'hFFFF_FFFF);
        rd_check("R2 select huge", 12'h7A0, 32'd1);
        wr(12'h7A0, 32'd0);
        rd_check("R2 select back", 12'h7A0, 32'd0);
    endtask

    task automatic t_cap;
        rd_check("R3 cap", 12'h7A4, 32'h44);
        wr(12'h7A4, 32'h0);
        rd_check("R3 cap after write", 12'h7A4, 32'h44);
    endtask

    task automatic t_kind2;
        wr(12'h7A0, 32'd0);
        wr(12'h7A1, 32'h2FFF_FFFF);
        rd_check("R4 all ones", 12'h7A1, 32'h2003_005F);
        check("R9 ctrl_o0", trig_ctrl_o[31:0], 32'h2003_005F);
        check("R9 ctrl_o1 untouched", trig_ctrl_o[63:32], 32'h2000_0000);
        wr(12'h7A1, 32'h2000_F0A5);
        rd_check("R4 mixed", 12'h7A1, 32'h2000_0005);
    endtask

    task automatic t_kind6;
        wr(12'h7A0, 32'd1);
        wr(12'h7A1, 32'h6FFF_FFFF);
        rd_check("R5 all ones size 15", 12'h7A1, 32'h6180_005F);
        wr(12'h7A1, 32'h6005_0048);
        rd_check("R5 size 5 kept", 12'h7A1, 32'h6005_0048);
        check("R9 ctrl_o1", trig_ctrl_o[63:32], 32'h6005_0048);
        wr(12'h7A1, 32'h6004_0001);
        rd_check("R5 size 4 dropped", 12'h7A1, 32'h6000_0001);
        wr(12'h7A1, 32'h6003_0000);
        rd_check("R5 size 3 kept", 12'h7A1, 32'h6003_0000);
    endtask

    task automatic t_other_kind;
        wr(12'h7A0, 32'd1);
        wr(12'h7A1, 32'h3000_0001);
        rd_check("R6 icount kind", 12'h7A1, 32'h6003_0000);
        wr(12'h7A1, 32'h0000_005F);
        rd_check("R6 kind 0", 12'h7A1, 32'h6003_0000);
        check("R6 ctrl_o0 untouched", trig_ctrl_o[31:0], 32'h2000_0005);
    endtask

    task automatic t_compare;
        wr(12'h7A0, 32'd0);
        wr(12'h7A2, 32'hDEAD_BEEF);
        wr(12'h7A0, 32'd1);
        wr(12'h7A2, 32'h1234_5678);
        rd_check("R7 cmp1", 12'h7A2, 32'h1234_5678);
        wr(12'h7A0, 32'd0);
        rd_check("R7 cmp0", 12'h7A2, 32'hDEAD_BEEF);
        check("R9 cmp_o0", trig_cmp_o[31:0], 32'hDEAD_BEEF);
        check("R9 cmp_o1", trig_cmp_o[63:32], 32'h1234_5678);
    endtask

    task automatic t_aux;
        wr(12'h7A3, 32'hFFFF_FFFF);
        rd_check("R8 aux reads zero", 12'h7A3, 32'h0);
        rd_check("R8 ctrl0 unchanged", 12'h7A1, 32'h2000_0005);
        check("R8 cmp_o0 unchanged", trig_cmp_o[31:0], 32'hDEAD_BEEF);
    endtask

    task automatic t_unmapped;
        wr(12'h7A5, 32'hFFFF_FFFF);
        rd_check("R10 unmapped read", 12'h7A5, 32'h0);
        rd_check("R10 select unchanged", 12'h7A0, 32'h0);
        check("R10 ctrl_o1 unchanged", trig_ctrl_o[63:32], 32'h6003_0000);
        check("R10 cmp_o1 unchanged", trig_cmp_o[63:32], 32'h1234_5678);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_select();
        t_cap();
        t_kind2();
        t_kind6();
        t_other_kind();
        t_compare();
        t_aux();
        t_unmapped();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule